// File: doc/BRIEF.md
# Two-Level Priority Bus Arbiter

This block decides which of six masters may drive a shared parallel bus. Position 0 belongs to the on-chip master and has the higher of two priority levels. Positions 1 to 5 belong to external devices and form a lower level. Within that lower level the devices take turns in a fixed rotation. Every request enters the block and every grant leaves it as an active-low signal. The board can therefore bypass this arbiter and use an external one, and any pair that is not needed can stay unconnected.

The grant is registered. It moves only at an arbitration point: a cycle in which the bus is reported idle, or in which the current owner has let go of its request. When no one requests the bus, the grant stays on the last owner. The on-chip master outranks the external group, but it cannot win two arbitration points in a row while an external device is waiting. This keeps the external group from being starved.

Top module: `bus_arb2`

## Requirements
- R1: Pair 0 (`req_n[0]`/`gnt_n[0]`) is the on-chip master and pairs 1 to 5 are external devices. Requests and grants are active low, and exactly one bit of `gnt_n` is 0 in every cycle.
- R2: During reset and in the first cycle after it, the grant rests on pair 0 (`gnt_n` = 6'b111110).
- R3: An arbitration point is a clock edge at which `bus_idle` is 1 or the granted pair's `req_n` is 1. At any other edge `gnt_n` keeps its value.
- R4: At an arbitration point where pair 0 requests, pair 0 wins if it did not win the previous arbitration point that had a requester.
- R5: If pair 0 won the previous arbitration point that had a requester and an external request is pending, an external device wins, even if pair 0 still requests.
- R6: An external winner is chosen in rotation. The search starts at the device after the last external device granted and wraps from 5 to 1. After reset the search starts at device 1.
- R7: At an arbitration point with no request pending, the grant stays on the last owner.
- R8: With only pair 0 requesting, pair 0 wins every arbitration point.
- R9: The result of an arbitration point at edge N appears on `gnt_n` after edge N, one register stage from the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_idle | input | 1 | 1 when the bus carries no transaction |
| req_n | input | 6 | Active-low requests; bit 0 is the on-chip master |
| gnt_n | output | 6 | Active-low one-hot grants; bit 0 is the on-chip master |

## Verification
The hardest case to reach is the on-chip master being refused. For that to happen, it must already hold the bus from a previous win, it must still be requesting, an external request must arrive, and the bus must then become idle or the owner must release. The stimulus builds this up on purpose. Pair 0 wins once, an external request is raised while the bus is busy so that the grant must hold, and then `bus_idle` is asserted. The same sequence also checks that the rotation pointer wraps and that grants stay parked both when the bus is idle and when the owner releases.

// File: rtl/bus_arb2.sv
module bus_arb2 #(
  parameter int N_EXT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_idle,
  input  logic [N_EXT:0]   req_n,
  output logic [N_EXT:0]   gnt_n
);
  localparam int N  = N_EXT + 1;
  localparam int IW = $clog2(N);

  logic [IW-1:0] owner_q, last_ext_q, rr_pick, next_owner;
  logic          hp_last_q, rr_found;
  logic [N-1:0]  req;
  logic          hp_req, ext_pend, any_req, rearb;

  assign req      = ~req_n;
  assign hp_req   = req[0];
  assign ext_pend = |req[N-1:1];
  assign any_req  = |req;
  assign rearb    = bus_idle | req_n[owner_q];

  always_comb begin
    int idx;
    logic [IW-1:0] cand;
    rr_pick  = '0;
    rr_found = 1'b0;
    for (int k = 1; k <= N_EXT; k++) begin
      idx = int'(last_ext_q) + k;
      if (idx > N_EXT) idx = idx - N_EXT;
      cand = IW'(idx);
      if (!rr_found && req[cand]) begin
        rr_found = 1'b1;
        rr_pick  = cand;
      end
    end
  end

  always_comb begin
    if (hp_req && (!hp_last_q || !ext_pend)) next_owner = '0;
    else if (rr_found)                       next_owner = rr_pick;
    else                                     next_owner = owner_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q    <= '0;
      last_ext_q <= IW'(N_EXT);
      hp_last_q  <= 1'b0;
    end else if (rearb && any_req) begin
      owner_q   <= next_owner;
      hp_last_q <= (next_owner == '0);
      if (next_owner != '0) last_ext_q <= next_owner;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_gnt
    assign gnt_n[g] = (owner_q != IW'(g));
  end
endmodule

// File: rtl/bus_arb2_chk.sv
module bus_arb2_chk #(
  parameter int N_EXT = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_idle,
  input logic [N_EXT:0] req_n,
  input logic [N_EXT:0] gnt_n
);
  logic ev, ext_p, anyr, ev_q, hp_won_q, hp_eff;

  assign ev     = bus_idle | (|(~gnt_n & req_n));
  assign ext_p  = |(~req_n[N_EXT:1]);
  assign anyr   = |(~req_n);
  assign hp_eff = ev_q ? ~gnt_n[0] : hp_won_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q     <= 1'b0;
      hp_won_q <= 1'b0;
    end else begin
      ev_q     <= ev && anyr;
      hp_won_q <= hp_eff;
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~gnt_n) == 1);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ev |=> $stable(gnt_n));
  p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !anyr |=> $stable(gnt_n));
  p_hp_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !req_n[0] && !hp_eff) |=> !gnt_n[0]);
  p_hp_yield_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && hp_eff && ext_p) |=> gnt_n[0]);
  p_hp_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !req_n[0] && !ext_p) |=> !gnt_n[0]);
endmodule

bind bus_arb2 bus_arb2_chk #(.N_EXT(N_EXT)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .req_n(req_n), .gnt_n(gnt_n));

// File: tb/bus_arb2_tb_top.sv
`timescale 1ns/1ps
module bus_arb2_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_idle = 1'b0;
  logic [5:0] req_n = 6'h3f;
  logic [5:0] gnt_n;

  int checks = 0;
  int fails  = 0;
  logic [5:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #2 clk = ~clk;

  bus_arb2 dut_i (.clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .req_n(req_n), .gnt_n(gnt_n));

  task automatic drive(input logic [5:0] active, input logic idle, input int win, input string tag);
    @(negedge clk);
    req_n    = ~active;
    bus_idle = idle;
    exp_q.push_back(~(6'b1 << win));
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [5:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (gnt_n !== e) begin
          fails++;
          $display("FAIL %s gnt_n actual=%b expected=%b", t, gnt_n, e);
        end
      end
    end
  end

  initial begin
    #10;
    checks++;
    if (gnt_n !== 6'b111110) begin
      fails++;
      $display("FAIL R2 reset gnt_n actual=%b expected=%b", gnt_n, 6'b111110);
    end
    @(negedge clk);
    rst_n = 1'b1;
    drive(6'b000000, 1, 0, "R7/R2 park after reset");
    drive(6'b000101, 1, 0, "R4 hp first win");
    drive(6'b000101, 1, 2, "R5/R6 hp yields to dev2");
    drive(6'b000101, 0, 2, "R3 hold while owner requests");
    drive(6'b011001, 0, 0, "R3/R4 owner release, hp wins");
    drive(6'b011001, 1, 3, "R5/R6 rotate to dev3");
    drive(6'b011000, 1, 4, "R6 rotate to dev4");
    drive(6'b001010, 1, 1, "R6 wrap to dev1");
    drive(6'b001010, 1, 3, "R6 next after dev1");
    drive(6'b000000, 1, 3, "R7 park on dev3");
    drive(6'b000001, 1, 0, "R4 hp wins");
    drive(6'b000001, 1, 0, "R8 hp alone again");
    drive(6'b100001, 0, 0, "R3 hold busy bus");
    drive(6'b100001, 1, 5, "R5 hp yields to dev5");
    drive(6'b000000, 0, 5, "R7 owner release, park");
    drive(6'b111110, 1, 1, "R6 rotation dev1");
    drive(6'b111110, 1, 2, "R6 rotation dev2");
    drive(6'b111110, 1, 3, "R6 rotation dev3");
    drive(6'b111110, 1, 4, "R6 rotation dev4");
    drive(6'b111110, 1, 5, "R9/R6 rotation dev5");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule